// File: doc/BRIEF.md
# Program Counter with Return Stack

This block produces the instruction fetch address for a small microcontroller core. A 13-bit counter spans a logical space of 8K words. Each cycle the counter either advances by one or holds. It can also load an absolute target, fall back to a fixed vector, or take an address back from a hardware return stack.

The stack is a circular file of eight 13-bit slots. A call saves the address of the next instruction. Interrupt entry saves the same address and then goes to the interrupt vector. Any return-type instruction restores the saved address. The physical program store is smaller than the logical space, so the fetch address is the counter folded onto the implemented words, and the upper bits are dropped. The raw counter value is also output, for use by the core.

The strobes come from instruction decode and from the interrupt controller. When more than one strobe is active in a cycle, a fixed priority picks one. The cycle after a strobe, the counter and the fetch address show its effect.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, the counter and the fetch address are 0000h. The stack pointer and all stack slots are cleared as well.
- R2: `step_i` alone advances the counter by one at the next clock edge. With no strobe active, the counter holds its value.
- R3: The counter is 13 bits wide, and advancing from 1FFFh gives 0000h.
- R4: `jump_i` alone loads `target_i` into the counter and leaves the stack untouched.
- R5: `call_i` loads `target_i` and pushes the counter value plus one. `ret_i` pops the most recent saved address into the counter. A single return strobe serves all three return-type instructions.
- R6: `irq_i` loads 0004h and pushes the counter value plus one.
- R7: Up to eight nested calls or interrupt entries are returned from in last-in, first-out order.
- R8: The stack pointer is a 3-bit circular index. A ninth push overwrites the slot of the oldest entry, and no flag is raised.
- R9: A pop with nothing saved returns whatever its slot holds. Straight after reset, that value is 0000h.
- R10: When several strobes are active together, the priority from highest to lowest is reset, `irq_i`, `ret_i`, `call_i`, `jump_i`, `step_i`. A `call_i` together with `jump_i` acts as a call.
- R11: `fetch_addr_o` equals the counter masked with IMPL_WORDS-1, and its upper bits are zero. IMPL_WORDS is 1024 or 2048 (default 2048, mask 07FFh). `pc_o` is the unmasked counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance counter by one |
| jump_i | input | 1 | Load target, no push |
| call_i | input | 1 | Load target, push return address |
| ret_i | input | 1 | Pop saved address into counter |
| irq_i | input | 1 | Interrupt entry: push, load vector 0004h |
| target_i | input | 13 | Absolute jump or call target |
| fetch_addr_o | output | 13 | Counter folded onto implemented space |
| pc_o | output | 13 | Raw counter value |

## Verification
A vector table drives single strobes and then pairs of strobes in the same cycle. The single strobes show that each path (advance, hold, load, push-and-load, pop, vector) has its own effect. The pairs show which strobe wins and whether the stack is pushed, popped or left alone. A chain of nine nested calls followed by nine returns tells true last-in-first-out order apart from the circular wrap, because the ninth return gives back the last value pushed. Targets placed above, on and just past the 07FFh boundary, together with the step from 1FFFh, separate folding of the fetch address from wrap of the counter itself.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   localparam int unsigned PC_WIDTH    = 13;
   localparam int unsigned STACK_SLOTS = 8;

   localparam logic [PC_WIDTH-1:0] RESET_VEC = 13'h0000;
   localparam logic [PC_WIDTH-1:0] IRQ_VEC   = 13'h0004;

   typedef enum logic [2:0] {
      NXT_HOLD = 3'd0,
      NXT_STEP = 3'd1,
      NXT_JUMP = 3'd2,
      NXT_CALL = 3'd3,
      NXT_RET  = 3'd4,
      NXT_IRQ  = 3'd5
   } nxt_sel_e;

endpackage

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
   import pcs_pkg::*;
(
   input  logic     irq_i,
   input  logic     ret_i,
   input  logic     call_i,
   input  logic     jump_i,
   input  logic     step_i,
   output nxt_sel_e sel_o,
   output logic     push_o,
   output logic     pop_o
);

   // fixed priority: interrupt, return, call, jump, step
   always_comb begin
      sel_o  = NXT_HOLD;
      push_o = 1'b0;
      pop_o  = 1'b0;
      if (irq_i) begin
         sel_o  = NXT_IRQ;
         push_o = 1'b1;
      end else if (ret_i) begin
         sel_o  = NXT_RET;
         pop_o  = 1'b1;
      end else if (call_i) begin
         sel_o  = NXT_CALL;
         push_o = 1'b1;
      end else if (jump_i) begin
         sel_o  = NXT_JUMP;
      end else if (step_i) begin
         sel_o  = NXT_STEP;
      end
   end

endmodule

// File: rtl/pcs_return_stack.sv
module pcs_return_stack #(
   parameter int unsigned WIDTH = 13,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [WIDTH-1:0] push_data_i,
   output logic [WIDTH-1:0] top_o
);

   localparam int unsigned PTR_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("pcs_return_stack: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [PTR_W-1:0] sp_q;
   logic [PTR_W-1:0] rd_idx;
   logic [WIDTH-1:0] slot_q [DEPTH];

   // sp_q names the next free slot; it wraps, so old entries get overwritten
   assign rd_idx = sp_q - PTR_W'(1);
   assign top_o  = slot_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) begin
            slot_q[i] <= '0;
         end
      end else if (push_i) begin
         slot_q[sp_q] <= push_data_i;
         sp_q         <= sp_q + PTR_W'(1);
      end else if (pop_i) begin
         sp_q <= rd_idx;
      end
   end

   // R7: a push advances and a pop retreats the circular index by one
   a_r7_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> sp_q == $past(sp_q) + PTR_W'(1));
   a_r7_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |=> sp_q == $past(sp_q) - PTR_W'(1));
   // R5: the value just pushed is what a pop would return next
   a_r5_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> top_o == $past(push_data_i));

endmodule

// File: rtl/pcs_addr_fold.sv
module pcs_addr_fold #(
   parameter int unsigned WIDTH      = 13,
   parameter int unsigned IMPL_WORDS = 2048
) (
   input  logic [WIDTH-1:0] pc_i,
   output logic [WIDTH-1:0] addr_o
);

   localparam int unsigned AW = $clog2(IMPL_WORDS);

   generate
      if (AW >= WIDTH) begin : g_full
         assign addr_o = pc_i;
      end else begin : g_fold
         assign addr_o = {{(WIDTH-AW){1'b0}}, pc_i[AW-1:0]};
      end
   endgenerate

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pcs_pkg::*;
#(
   parameter int unsigned PC_W       = PC_WIDTH,
   parameter int unsigned DEPTH      = STACK_SLOTS,
   parameter int unsigned IMPL_WORDS = 2048
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_i,
   input  logic            jump_i,
   input  logic            call_i,
   input  logic            ret_i,
   input  logic            irq_i,
   input  logic [PC_W-1:0] target_i,
   output logic [PC_W-1:0] fetch_addr_o,
   output logic [PC_W-1:0] pc_o
);

   localparam int unsigned AW = $clog2(IMPL_WORDS);

   generate
      if (IMPL_WORDS != 1024 && IMPL_WORDS != 2048) begin : g_bad_impl
         $error("pc_sequencer: IMPL_WORDS must be 1024 or 2048");
      end
      if (PC_W <= AW) begin : g_bad_width
         $error("pc_sequencer: PC_W must exceed the implemented address width");
      end
   endgenerate

   nxt_sel_e        sel;
   logic            push, pop;
   logic [PC_W-1:0] pc_q, pc_d, pc_inc, stk_top;

   pcs_next_sel u_sel (
      .irq_i  (irq_i),
      .ret_i  (ret_i),
      .call_i (call_i),
      .jump_i (jump_i),
      .step_i (step_i),
      .sel_o  (sel),
      .push_o (push),
      .pop_o  (pop)
   );

   assign pc_inc = pc_q + PC_W'(1);

   pcs_return_stack #(.WIDTH(PC_W), .DEPTH(DEPTH)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .pop_i       (pop),
      .push_data_i (pc_inc),
      .top_o       (stk_top)
   );

   always_comb begin
      unique case (sel)
         NXT_IRQ:  pc_d = PC_W'(IRQ_VEC);
         NXT_RET:  pc_d = stk_top;
         NXT_CALL: pc_d = target_i;
         NXT_JUMP: pc_d = target_i;
         NXT_STEP: pc_d = pc_inc;
         default:  pc_d = pc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= PC_W'(RESET_VEC);
      else        pc_q <= pc_d;
   end

   pcs_addr_fold #(.WIDTH(PC_W), .IMPL_WORDS(IMPL_WORDS)) u_fold (
      .pc_i   (pc_q),
      .addr_o (fetch_addr_o)
   );

   assign pc_o = pc_q;

   // R1: counter sits at the reset vector while reset is held
   always @(posedge clk) begin
      if (!rst_n) a_r1_reset_pc: assert (pc_o == PC_W'(RESET_VEC));
   end

   // R6: interrupt entry lands on the vector
   a_r6_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i |=> pc_o == PC_W'(IRQ_VEC));
   // R6: interrupt entry saves the next address
   a_r6_irq_saves: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i |=> stk_top == $past(pc_o) + PC_W'(1));
   // R5: a winning call saves the next address
   a_r5_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !irq_i && !ret_i) |=> stk_top == $past(pc_o) + PC_W'(1));
   // R4: a lone jump loads the target
   a_r4_jump_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_i && !call_i && !ret_i && !irq_i) |=> pc_o == $past(target_i));
   // R2: a lone step advances by one
   a_r2_step_adds: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !jump_i && !call_i && !ret_i && !irq_i) |=> pc_o == $past(pc_o) + PC_W'(1));
   // R2: with no strobe the counter holds
   a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_i || jump_i || call_i || ret_i || irq_i) |=> $stable(pc_o));
   // R11: fetch address never leaves the implemented space
   a_r11_fold_range: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_addr_o >> AW) == '0);

endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0, jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, irq_i = 1'b0;
   logic [12:0] target_i = '0;
   logic [12:0] fetch_addr_o, pc_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pc_sequencer u_pc_sequencer (
      .clk          (clk),
      .rst_n        (rst_n),
      .step_i       (step_i),
      .jump_i       (jump_i),
      .call_i       (call_i),
      .ret_i        (ret_i),
      .irq_i        (irq_i),
      .target_i     (target_i),
      .fetch_addr_o (fetch_addr_o),
      .pc_o         (pc_o)
   );

   // vector: {irq, ret, call, jump, step, target[12:0], expected pc[12:0]}
   localparam int NVEC = 18;
   localparam logic [30:0] VEC [NVEC] = '{
      {5'b00001, 13'h0000, 13'h0001},  // R2 step
      {5'b00001, 13'h0000, 13'h0002},  // R2 step
      {5'b00010, 13'h0ABC, 13'h0ABC},  // R4 jump
      {5'b00100, 13'h0100, 13'h0100},  // R5 call, saves 0ABD
      {5'b00001, 13'h0000, 13'h0101},  // R2 step
      {5'b00100, 13'h0200, 13'h0200},  // R5 call, saves 0102
      {5'b01000, 13'h0000, 13'h0102},  // R7 return inner
      {5'b01000, 13'h0000, 13'h0ABD},  // R7 return outer
      {5'b10000, 13'h0000, 13'h0004},  // R6 irq, saves 0ABE
      {5'b01000, 13'h0000, 13'h0ABE},  // R6 return from irq
      {5'b00010, 13'h1FFF, 13'h1FFF},  // R4 jump to top
      {5'b00001, 13'h0000, 13'h0000},  // R3 wrap
      {5'b00011, 13'h0050, 13'h0050},  // R10 jump beats step
      {5'b00110, 13'h0300, 13'h0300},  // R10 call beats jump, saves 0051
      {5'b01100, 13'h0400, 13'h0051},  // R10 return beats call, no push
      {5'b11000, 13'h0000, 13'h0004},  // R10 irq beats return, saves 0052
      {5'b01000, 13'h0000, 13'h0052},  // R10 return after irq
      {5'b00000, 13'h0000, 13'h0052}   // R2 hold
   };

   task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [4:0] s, input logic [12:0] tgt);
      @(negedge clk);
      {irq_i, ret_i, call_i, jump_i, step_i} = s;
      target_i = tgt;
      @(posedge clk);
      #1;
      {irq_i, ret_i, call_i, jump_i, step_i} = 5'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #800000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #1;
      check("R1 reset pc", pc_o, 13'h0000);
      check("R1 reset fetch", fetch_addr_o, 13'h0000);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: pop straight after reset returns the cleared slot
      apply(5'b01000, 13'h0000);
      check("R9 empty pop after reset", pc_o, 13'h0000);

      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][30:26], VEC[i][25:13]);
         check($sformatf("vector %0d", i), pc_o, VEC[i][12:0]);
      end

      // R11: folding at and around the implemented boundary
      apply(5'b00010, 13'h0ABC);
      check("R11 fetch fold 0ABC", fetch_addr_o, 13'h02BC);
      check("R11 raw pc kept", pc_o, 13'h0ABC);
      apply(5'b00010, 13'h07FF);
      check("R11 fetch at 07FF", fetch_addr_o, 13'h07FF);
      apply(5'b00001, 13'h0000);
      check("R11 fetch 0800 wraps", fetch_addr_o, 13'h0000);
      check("R11 raw pc 0800", pc_o, 13'h0800);
      apply(5'b00010, 13'h1FFF);
      check("R11 fetch 1FFF", fetch_addr_o, 13'h07FF);

      // R7/R8: nine nested calls, then nine returns
      apply(5'b00010, 13'h0020);
      for (int k = 1; k <= 9; k++) begin
         apply(5'b00100, 13'(k * 256));
      end
      check("R8 after ninth call", pc_o, 13'h0900);
      for (int i = 1; i <= 8; i++) begin
         apply(5'b01000, 13'h0000);
         check($sformatf("R7 return %0d", i), pc_o, 13'((9 - i) * 256 + 1));
      end
      apply(5'b01000, 13'h0000);
      check("R8 overwritten oldest slot", pc_o, 13'h0801);

      // R1: reset in the middle of activity
      apply(5'b00010, 13'h0456);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid-run reset pc", pc_o, 13'h0000);
      check("R1 mid-run reset fetch", fetch_addr_o, 13'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      apply(5'b01000, 13'h0000);
      check("R9 empty pop after second reset", pc_o, 13'h0000);

      finish_run();
   end

endmodule